// File: doc/BRIEF.md
# Branch and Bit-Test Condition Evaluator

This block decides whether a conditional branch is taken. It serves a processor core and takes two kinds of input. A flag branch is decided from the four status flags: negative, overflow, carry and zero. A bit-test branch is decided from the opcode byte and a data byte that was fetched earlier. A 4-bit condition select picks one of eight flag tests, an unconditional branch, or the bit-test mode.

In bit-test mode the opcode itself carries the whole test. A 3-bit field of the opcode, starting at bit 4, gives the index of the data bit to examine. The opcode's top bit gives the polarity. When the top bit is 1, the branch is taken if the examined bit is 1. When the top bit is 0, the branch is taken if the examined bit is 0.

The decision is registered. It is also qualified by an input valid strobe, so the single taken output is a clean flop output one cycle after the request. The block does not compute the target address, fetch operands or flush the pipeline.

Top module: `brcond_eval`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `br_taken` is 0 after that edge (synchronous, active-low reset).
- R2: If `in_valid` is 0 at a rising edge, `br_taken` is 0 after that edge, whatever the other inputs are.
- R3: Select 0 is taken when N is 0. Select 1 is taken when N is 1.
- R4: Select 2 is taken when V is 0. Select 3 is taken when V is 1.
- R5: Select 4 is taken when C is 0. Select 5 is taken when C is 1.
- R6: Select 6 is taken when Z is 0. Select 7 is taken when Z is 1.
- R7: Select 8 is always taken.
- R8: Select 9 is bit-test mode. When opcode bit 7 is 1, the branch is taken exactly when `test_byte` bit `opcode[6:4]` is 1.
- R9: In bit-test mode with opcode bit 7 equal to 0, the branch is taken exactly when `test_byte` bit `opcode[6:4]` is 0.
- R10: Select codes 10 to 15 are never taken.
- R11: A request sampled at a rising edge shows on `br_taken` immediately after that same edge and not before it. The latency is one register.
- R12: The flags have no effect in bit-test mode, and `opcode` and `test_byte` have no effect in the flag and unconditional modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe; when 0, no branch is reported |
| cond_sel | input | 4 | Condition select (0-7 flag tests, 8 always, 9 bit-test, 10-15 undefined) |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| opcode | input | 8 | Branch opcode; bits 6:4 are the bit index and bit 7 is the polarity |
| test_byte | input | 8 | Data byte examined in bit-test mode |
| br_taken | output | 1 | Registered branch decision |

## Verification
Every decision is due exactly one rising edge after its inputs are sampled. The bench drives each request on a falling edge and compares `br_taken` on the following falling edge, which is half a period after the register has updated. The latency check also samples just after driving and before the edge, to show that the old value is still present there. Reset and idle checks use the same one-edge spacing. The sweeps cover all sixteen select codes against all sixteen flag patterns, and every opcode against every data byte in bit-test mode.

// File: rtl/brcond_pkg.sv
// Package: shared condition-select encoding for the branch evaluator.
// Assumes a 4-bit select; codes above SEL_BITTEST are undefined.
package brcond_pkg;

    localparam int SEL_W = 4;

    typedef enum logic [SEL_W-1:0] {
        SEL_N_CLR   = 4'd0,
        SEL_N_SET   = 4'd1,
        SEL_V_CLR   = 4'd2,
        SEL_V_SET   = 4'd3,
        SEL_C_CLR   = 4'd4,
        SEL_C_SET   = 4'd5,
        SEL_Z_CLR   = 4'd6,
        SEL_Z_SET   = 4'd7,
        SEL_ALWAYS  = 4'd8,
        SEL_BITTEST = 4'd9
    } brsel_e;

endpackage

// File: rtl/brcond_flag_unit.sv
// Module: flag-condition decoder.
// Turns a condition select and the N/V/C/Z flags into a combinational hit.
// Assumes: bit-test and undefined codes return 0 here; the top handles bit-test.
module brcond_flag_unit
    import brcond_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  logic             flag_n,
    input  logic             flag_v,
    input  logic             flag_c,
    input  logic             flag_z,
    output logic             hit
);

    // Purpose: pick a flag and its required polarity from the select code.
    always_comb begin
        case (sel)
            SEL_N_CLR:  hit = ~flag_n;
            SEL_N_SET:  hit =  flag_n;
            SEL_V_CLR:  hit = ~flag_v;
            SEL_V_SET:  hit =  flag_v;
            SEL_C_CLR:  hit = ~flag_c;
            SEL_C_SET:  hit =  flag_c;
            SEL_Z_CLR:  hit = ~flag_z;
            SEL_Z_SET:  hit =  flag_z;
            SEL_ALWAYS: hit = 1'b1;
            default:    hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/brcond_bit_unit.sv
// Module: bit-test decoder.
// Takes the bit index from the opcode field at IDX_LSB and the polarity from
// the opcode's top bit. It reports a hit when the chosen bit of the data
// equals that polarity.
// Assumes: IDX_LSB + log2(DATA_W) <= DATA_W - 1, so the index field and the
// polarity bit do not overlap.
module brcond_bit_unit #(
    parameter int DATA_W  = 8,
    parameter int IDX_LSB = 4
) (
    input  logic [DATA_W-1:0] opcode,
    input  logic [DATA_W-1:0] test_byte,
    output logic              hit
);

    localparam int IDX_W   = $clog2(DATA_W);
    localparam int POL_BIT = DATA_W - 1;

    logic [IDX_W-1:0]  bit_idx;
    logic [DATA_W-1:0] one_hot;
    logic              picked;
    logic              unused_op_low;

    assign bit_idx       = opcode[IDX_LSB +: IDX_W];
    assign unused_op_low = ^opcode[IDX_LSB-1:0];

    // Purpose: decode the index field into a one-hot mask, one lane per data bit.
    for (genvar i = 0; i < DATA_W; i++) begin : g_lane
        assign one_hot[i] = (bit_idx == IDX_W'(i));
    end

    // Purpose: extract the chosen bit and compare it with the required polarity.
    always_comb begin
        picked = |(one_hot & test_byte);
        hit    = (picked == opcode[POL_BIT]);
    end

endmodule

// File: rtl/brcond_eval.sv
// Module: branch and bit-test condition evaluator (top).
// Chooses between the flag decoder and the bit-test decoder, qualifies the
// result with in_valid, and registers it on br_taken.
// Assumes: synchronous active-low reset; one-cycle latency from request to result.
module brcond_eval
    import brcond_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int IDX_LSB = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [SEL_W-1:0]  cond_sel,
    input  logic              flag_n,
    input  logic              flag_v,
    input  logic              flag_c,
    input  logic              flag_z,
    input  logic [DATA_W-1:0] opcode,
    input  logic [DATA_W-1:0] test_byte,
    output logic              br_taken
);

    localparam int IDX_W   = $clog2(DATA_W);
    localparam int POL_BIT = DATA_W - 1;

    logic flag_hit;
    logic bit_hit;
    logic decision;

    brcond_flag_unit u_flag (
        .sel    (cond_sel),
        .flag_n (flag_n),
        .flag_v (flag_v),
        .flag_c (flag_c),
        .flag_z (flag_z),
        .hit    (flag_hit)
    );

    brcond_bit_unit #(
        .DATA_W  (DATA_W),
        .IDX_LSB (IDX_LSB)
    ) u_bit (
        .opcode    (opcode),
        .test_byte (test_byte),
        .hit       (bit_hit)
    );

    // Purpose: route the bit-test result in bit-test mode, else the flag result.
    always_comb begin
        decision = (cond_sel == SEL_BITTEST) ? bit_hit : flag_hit;
    end

    // Purpose: register the valid-qualified decision; clear it in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            br_taken <= 1'b0;
        end else begin
            br_taken <= in_valid & decision;
        end
    end

    // R1: reset forces not-taken
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> !br_taken);

    // R2: idle cycle gives not-taken
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !br_taken);

    // R3: N set branch follows the flag
    a_r3_n_set: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond_sel == SEL_N_SET) |=> (br_taken == $past(flag_n)));

    // R5: carry clear branch follows the inverted flag
    a_r5_c_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond_sel == SEL_C_CLR) |=> (br_taken == !$past(flag_c)));

    // R7: unconditional form
    a_r7_always: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond_sel == SEL_ALWAYS) |=> br_taken);

    // R8: test-for-set on the indexed data bit
    a_r8_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond_sel == SEL_BITTEST && opcode[POL_BIT])
        |=> (br_taken == $past(test_byte[opcode[IDX_LSB +: IDX_W]])));

    // R9: test-for-clear on the indexed data bit
    a_r9_bit_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond_sel == SEL_BITTEST && !opcode[POL_BIT])
        |=> (br_taken == !$past(test_byte[opcode[IDX_LSB +: IDX_W]])));

    // R10: undefined select codes
    a_r10_undef: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond_sel > SEL_BITTEST) |=> !br_taken);

endmodule

// File: tb/brcond_eval_tb.sv
`timescale 1ns/100ps
module brcond_eval_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid;
    logic [3:0] cond_sel;
    logic       flag_n, flag_v, flag_c, flag_z;
    logic [7:0] opcode, test_byte;
    logic       br_taken;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    brcond_eval u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cond_sel(cond_sel),
        .flag_n(flag_n), .flag_v(flag_v), .flag_c(flag_c), .flag_z(flag_z),
        .opcode(opcode), .test_byte(test_byte), .br_taken(br_taken)
    );

    // Directed vectors: {sel, nvcz, opcode, test_byte, expected}
    localparam logic [24:0] VEC [0:14] = '{
        {4'd0,  4'b0000, 8'h00, 8'h00, 1'b1},
        {4'd1,  4'b1000, 8'h00, 8'h00, 1'b1},
        {4'd1,  4'b0000, 8'h00, 8'h00, 1'b0},
        {4'd3,  4'b0100, 8'h00, 8'h00, 1'b1},
        {4'd2,  4'b0100, 8'h00, 8'h00, 1'b0},
        {4'd5,  4'b0010, 8'h00, 8'h00, 1'b1},
        {4'd4,  4'b0010, 8'h00, 8'h00, 1'b0},
        {4'd7,  4'b0001, 8'h00, 8'h00, 1'b1},
        {4'd6,  4'b0000, 8'h00, 8'h00, 1'b1},
        {4'd8,  4'b0000, 8'h00, 8'h00, 1'b1},
        {4'd9,  4'b0000, 8'hB7, 8'h08, 1'b1},
        {4'd9,  4'b0000, 8'h37, 8'h08, 1'b0},
        {4'd9,  4'b1111, 8'h77, 8'h7F, 1'b1},
        {4'd12, 4'b1111, 8'hFF, 8'hFF, 1'b0},
        {4'd15, 4'b0000, 8'h00, 8'h00, 1'b0}
    };

    function automatic logic model(int sel, logic [3:0] f, logic [7:0] op, logic [7:0] tb);
        case (sel)
            0: return !f[3];
            1: return  f[3];
            2: return !f[2];
            3: return  f[2];
            4: return !f[1];
            5: return  f[1];
            6: return !f[0];
            7: return  f[0];
            8: return 1'b1;
            9: return ((tb >> op[6:4]) & 8'h01) == {7'd0, op[7]};
            default: return 1'b0;
        endcase
    endfunction

    function automatic string tag_of(int sel, logic [7:0] op);
        case (sel)
            0, 1: return "R3";
            2, 3: return "R4";
            4, 5: return "R5";
            6, 7: return "R6";
            8:    return "R7";
            9:    return op[7] ? "R8" : "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(logic exp, string tag);
        checks++;
        if (br_taken !== exp) begin
            fails++;
            $display("FAIL %s br_taken=%0b expected=%0b", tag, br_taken, exp);
        end
    endtask

    task automatic drive(logic v, int sel, logic [3:0] f, logic [7:0] op, logic [7:0] tb);
        in_valid  = v;
        cond_sel  = 4'(sel);
        {flag_n, flag_v, flag_c, flag_z} = f;
        opcode    = op;
        test_byte = tb;
    endtask

    // Watchdog: a hung run is counted as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired br_taken=%0b expected=done", br_taken);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        drive(1'b1, 8, 4'h0, 8'h00, 8'h00);
        @(negedge clk);
        @(negedge clk);
        chk(1'b0, "R1");                 // reset state with a taken request pending
        rst_n = 1'b1;

        // Directed table, one request per cycle, checked one edge later.
        for (int k = 0; k < 15; k++) begin
            drive(1'b1, int'(VEC[k][24:21]), VEC[k][20:17], VEC[k][16:9], VEC[k][8:1]);
            @(negedge clk);
            chk(VEC[k][0], tag_of(int'(VEC[k][24:21]), VEC[k][16:9]));
        end

        // All selects against all flag patterns; opcode and data vary (R12).
        for (int s = 0; s < 16; s++) begin
            for (int f = 0; f < 16; f++) begin
                logic [7:0] op, tb;
                op = 8'(s * 37 + f * 11);
                tb = 8'(~(s * 13 + f * 29));
                drive(1'b1, s, 4'(f), op, tb);
                @(negedge clk);
                chk(model(s, 4'(f), op, tb), {tag_of(s, op), "/R12"});
            end
        end

        // Bit-test: every opcode against every data byte; flags vary (R12).
        for (int o = 0; o < 256; o++) begin
            for (int t = 0; t < 256; t++) begin
                drive(1'b1, 9, 4'(o ^ t), 8'(o), 8'(t));
                @(negedge clk);
                chk(model(9, 4'(o ^ t), 8'(o), 8'(t)), {tag_of(9, 8'(o)), "/R12"});
            end
        end

        // R2: invalid request with an always-taken select
        drive(1'b0, 8, 4'hF, 8'hFF, 8'hFF);
        @(negedge clk);
        chk(1'b0, "R2");

        // R11: result absent before the edge, present after it
        drive(1'b1, 8, 4'h0, 8'h00, 8'h00);
        #1;
        chk(1'b0, "R11");
        @(negedge clk);
        chk(1'b1, "R11");

        // R1: reset taken mid-stream overrides a valid taken request
        rst_n = 1'b0;
        @(negedge clk);
        chk(1'b0, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        chk(1'b1, "R7");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule